// File: doc/BRIEF.md
# Kernel Launch and Status Register Slave

This block is the software-facing control port of a frame-based processing kernel. A host on an AXI4-Lite bus programs two frame-buffer base addresses and two 8-bit configuration fields, launches the kernel, and then either polls a status word or waits for an interrupt. The block turns a software launch into a level start request that the kernel acknowledges with a ready pulse. It records the kernel's completion pulse, mirrors its idle level, and raises one interrupt line according to the enable settings.

An auto-restart mode keeps the start request asserted across every acknowledge, so the kernel processes frame after frame without further bus traffic. Clearing that mode lets the run in progress finish, and then the kernel stops. Frame-buffer addresses and configuration fields go to the kernel as plain register outputs. They change only when the bus writes them.

Top module: `accel_ctl_slave`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x04, meaning idle is set and every other bit is clear. Every other register reads zero, `irq` is low and `k_start` is low.
- R2: The frame-buffer registers at 0x10 (source) and 0x18 (destination) are 32-bit read/write registers. The configuration fields at 0x20 (pixel format) and 0x28 (mode select) hold bits 7:0, and their upper bits read zero. Each byte lane is written only when its `s_wstrb` bit is set.
- R3: Offsets 0x14, 0x1C, 0x24 and 0x2C, and any address outside the map, read zero, and writes to them change nothing. In the control word, bits 1, 2 and 3 are read-only.
- R4: Writing 1 to control bit 0 with strobe 0 set raises `k_start`. When auto-restart is off, start clears on the cycle after the kernel asserts `k_ready`. Writing 0 to bit 0 has no effect.
- R5: Control bit 1 (done) is set when `k_done` rises. It stays set until the control word is read over the bus, and that read clears it.
- R6: Control bit 2 (idle) follows `k_idle` with a one-cycle delay. Control bit 3 (ready) follows `k_ready` with a one-cycle delay.
- R7: Status register 0x0C has bit 0 for done events and bit 1 for ready events. A bit is set on the rising edge of `k_done` or `k_ready`, whatever the enable settings. Writing 1 to a bit toggles it, and writing 0 leaves it unchanged.
- R8: `irq` equals global enable (0x04 bit 0) AND the OR over both bits of (status AND enable register 0x08 bits 1:0).
- R9: Control bit 7 is auto-restart. While it is set, start stays asserted through every kernel acknowledge, so the kernel re-launches after each completion. A single write of 0x81 both launches the kernel and enables the mode.
- R10: `fb_src_addr`, `fb_dst_addr`, `pix_format` and `mode_sel` always equal their registers, and they change only on a bus write.
- R11: Every write and every read gets exactly one response, with code OKAY (0). Each response is held until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| k_start | output | 1 | Start request to the kernel |
| k_done | input | 1 | Kernel completion pulse |
| k_idle | input | 1 | Kernel idle level |
| k_ready | input | 1 | Kernel acknowledge of start |
| fb_src_addr | output | FB_W | Source frame-buffer base |
| fb_dst_addr | output | FB_W | Destination frame-buffer base |
| pix_format | output | CFG_W | Pixel format field |
| mode_sel | output | CFG_W | Processing mode field |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the kernel follows the launch handshake. It raises `k_ready` only while `k_start` is high, and it reports `k_done` as isolated one-cycle pulses. They also assume the bus master keeps address and data valid until the block accepts them. The bench's kernel model meets the first assumption by construction, because it derives its acknowledge from `k_start` and its idle state and emits done after a fixed latency. The bench's bus tasks meet the second: they raise address and data valid together, hold them until the ready is seen, and keep both response readies high.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;

    // Register offsets (byte addresses) decoded by software
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_GIE    = 8'h04;
    localparam logic [7:0] OFS_IEN    = 8'h08;
    localparam logic [7:0] OFS_IST    = 8'h0C;
    localparam logic [7:0] OFS_FB_SRC = 8'h10;
    localparam logic [7:0] OFS_FB_DST = 8'h18;
    localparam logic [7:0] OFS_FMT    = 8'h20;
    localparam logic [7:0] OFS_MODE   = 8'h28;

    // Control word bit positions
    localparam int BIT_START = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_IDLE  = 2;
    localparam int BIT_RDY   = 3;
    localparam int BIT_AUTO  = 7;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef struct packed {
        logic        bvalid;
        logic        rvalid;
        logic [31:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/accel_ctl_bus_port.sv
module accel_ctl_bus_port
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_strb,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data
);

    bus_state_t st_d, st_q;
    logic       aw_take, ar_take;

    always_comb begin
        aw_take = awvalid && wvalid && !st_q.bvalid;
        ar_take = arvalid && !st_q.rvalid;
        st_d    = st_q;
        if (st_q.bvalid && bready) st_d.bvalid = 1'b0;
        if (aw_take)               st_d.bvalid = 1'b1;
        if (st_q.rvalid && rready) st_d.rvalid = 1'b0;
        if (ar_take) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign awready = aw_take;
    assign wready  = aw_take;
    assign arready = !st_q.rvalid;
    assign bvalid  = st_q.bvalid;
    assign rvalid  = st_q.rvalid;
    assign rdata   = st_q.rdata;
    assign wr_en   = aw_take;
    assign wr_addr = awaddr;
    assign wr_data = wdata;
    assign wr_strb = wstrb;
    assign rd_en   = ar_take;
    assign rd_addr = araddr;

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int FB_W   = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_strb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              k_start,
    input  logic              k_done,
    input  logic              k_idle,
    input  logic              k_ready,
    output logic [FB_W-1:0]   fb_src_addr,
    output logic [FB_W-1:0]   fb_dst_addr,
    output logic [CFG_W-1:0]  pix_format,
    output logic [CFG_W-1:0]  mode_sel,
    output logic              irq,
    output logic              auto_on
);

    localparam int NSRC = 2;

    typedef struct packed {
        logic             start;
        logic             done;
        logic             idle;
        logic             rdy;
        logic             auto_rs;
        logic             gie;
        logic [NSRC-1:0]  ien;
        logic [NSRC-1:0]  ist;
        logic [FB_W-1:0]  fb_src;
        logic [FB_W-1:0]  fb_dst;
        logic [CFG_W-1:0] fmt;
        logic [CFG_W-1:0] mode;
        logic             done_prev;
        logic             rdy_prev;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic [NSRC-1:0] rise;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return (a >> 2) == (ADDR_W'(ofs) >> 2);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old,
                                          input logic [31:0] nw,
                                          input logic [3:0]  be);
        logic [31:0] res;
        res = old;
        for (int b = 0; b < 4; b++)
            if (be[b]) res[8*b +: 8] = nw[8*b +: 8];
        return res;
    endfunction

    always_comb begin
        r_d         = r_q;
        rise        = {k_ready && !r_q.rdy_prev, k_done && !r_q.done_prev};
        r_d.done_prev = k_done;
        r_d.rdy_prev  = k_ready;
        r_d.idle    = k_idle;
        r_d.rdy     = k_ready;

        // kernel acknowledge: keep start only in auto-restart mode
        if (r_q.start && k_ready) r_d.start = r_q.auto_rs;

        if (rd_en && hit(rd_addr, OFS_CTRL)) r_d.done = 1'b0;

        if (wr_en) begin
            if (hit(wr_addr, OFS_CTRL) && wr_strb[0]) begin
                r_d.auto_rs = wr_data[BIT_AUTO];
                if (wr_data[BIT_START]) r_d.start = 1'b1;
            end
            if (hit(wr_addr, OFS_GIE) && wr_strb[0]) r_d.gie = wr_data[0];
            if (hit(wr_addr, OFS_IEN) && wr_strb[0]) r_d.ien = wr_data[NSRC-1:0];
            if (hit(wr_addr, OFS_IST) && wr_strb[0]) r_d.ist = r_q.ist ^ wr_data[NSRC-1:0];
            if (hit(wr_addr, OFS_FB_SRC))
                r_d.fb_src = FB_W'(merge(32'(r_q.fb_src), wr_data, wr_strb));
            if (hit(wr_addr, OFS_FB_DST))
                r_d.fb_dst = FB_W'(merge(32'(r_q.fb_dst), wr_data, wr_strb));
            if (hit(wr_addr, OFS_FMT) && wr_strb[0]) r_d.fmt = wr_data[CFG_W-1:0];
            if (hit(wr_addr, OFS_MODE) && wr_strb[0]) r_d.mode = wr_data[CFG_W-1:0];
        end

        // kernel events take priority over clear-on-read and toggles
        if (rise[0]) r_d.done = 1'b1;
        for (int s = 0; s < NSRC; s++)
            if (rise[s]) r_d.ist[s] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.idle <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit(rd_addr, OFS_CTRL)) begin
            rd_data[BIT_START] = r_q.start;
            rd_data[BIT_DONE]  = r_q.done;
            rd_data[BIT_IDLE]  = r_q.idle;
            rd_data[BIT_RDY]   = r_q.rdy;
            rd_data[BIT_AUTO]  = r_q.auto_rs;
        end
        if (hit(rd_addr, OFS_GIE))    rd_data[0] = r_q.gie;
        if (hit(rd_addr, OFS_IEN))    rd_data[NSRC-1:0] = r_q.ien;
        if (hit(rd_addr, OFS_IST))    rd_data[NSRC-1:0] = r_q.ist;
        if (hit(rd_addr, OFS_FB_SRC)) rd_data = 32'(r_q.fb_src);
        if (hit(rd_addr, OFS_FB_DST)) rd_data = 32'(r_q.fb_dst);
        if (hit(rd_addr, OFS_FMT))    rd_data[CFG_W-1:0] = r_q.fmt;
        if (hit(rd_addr, OFS_MODE))   rd_data[CFG_W-1:0] = r_q.mode;
    end

    assign k_start     = r_q.start;
    assign fb_src_addr = r_q.fb_src;
    assign fb_dst_addr = r_q.fb_dst;
    assign pix_format  = r_q.fmt;
    assign mode_sel    = r_q.mode;
    assign irq         = r_q.gie && |(r_q.ist & r_q.ien);
    assign auto_on     = r_q.auto_rs;

endmodule

// File: rtl/accel_ctl_slave.sv
module accel_ctl_slave
    import accel_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int FB_W   = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              k_start,
    input  logic              k_done,
    input  logic              k_idle,
    input  logic              k_ready,
    output logic [FB_W-1:0]   fb_src_addr,
    output logic [FB_W-1:0]   fb_dst_addr,
    output logic [CFG_W-1:0]  pix_format,
    output logic [CFG_W-1:0]  mode_sel,
    output logic              irq
);

    logic              wr_en, rd_en, auto_on;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [31:0]       wr_data, rd_data;
    logic [3:0]        wr_strb;

    accel_ctl_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    accel_ctl_regs #(.ADDR_W(ADDR_W), .FB_W(FB_W), .CFG_W(CFG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_strb     (wr_strb),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .k_start     (k_start),
        .k_done      (k_done),
        .k_idle      (k_idle),
        .k_ready     (k_ready),
        .fb_src_addr (fb_src_addr),
        .fb_dst_addr (fb_dst_addr),
        .pix_format  (pix_format),
        .mode_sel    (mode_sel),
        .irq         (irq),
        .auto_on     (auto_on)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/accel_ctl_checker.sv
module accel_ctl_checker #(
    parameter int ADDR_W = 6,
    parameter int FB_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] s_awaddr,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic [31:0]       s_wdata,
    input logic [3:0]        s_wstrb,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic              k_start,
    input logic              k_ready,
    input logic [FB_W-1:0]   fb_src_addr,
    input logic [FB_W-1:0]   fb_dst_addr,
    input logic              auto_on
);

    logic wr_take, start_wr;
    assign wr_take  = s_awvalid && s_awready;
    assign start_wr = wr_take && ((s_awaddr >> 2) == '0) && s_wstrb[0] && s_wdata[0];

    // R4: acknowledged start drops when auto-restart is off and no new launch
    a_r4_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (k_start && k_ready && !auto_on && !start_wr) |=> !k_start);

    // R9: auto-restart keeps the request alive through an acknowledge
    a_r9_auto_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
        (k_start && k_ready && auto_on) |=> k_start);

    // R11: responses held until accepted
    a_r11_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);
    a_r11_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> s_rvalid);

    // R10: buffer addresses move only on a bus write
    a_r10_src_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_take |=> $stable(fb_src_addr));
    a_r10_dst_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_take |=> $stable(fb_dst_addr));

endmodule

bind accel_ctl_slave accel_ctl_checker #(.ADDR_W(ADDR_W), .FB_W(FB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_awaddr    (s_awaddr),
    .s_awvalid   (s_awvalid),
    .s_awready   (s_awready),
    .s_wdata     (s_wdata),
    .s_wstrb     (s_wstrb),
    .s_bvalid    (s_bvalid),
    .s_bready    (s_bready),
    .s_rvalid    (s_rvalid),
    .s_rready    (s_rready),
    .k_start     (k_start),
    .k_ready     (k_ready),
    .fb_src_addr (fb_src_addr),
    .fb_dst_addr (fb_dst_addr),
    .auto_on     (auto_on)
);

// File: tb/test_accel_ctl_slave.sv
`timescale 1ns/1ps
module test_accel_ctl_slave;

    localparam int ADDR_W = 6;
    localparam int LAT    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
    logic              s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic              s_bready = 1'b1, s_rready = 1'b1;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]        s_bresp, s_rresp;
    logic [31:0]       s_rdata;
    logic              k_start, k_done, k_idle, k_ready, irq;
    logic [31:0]       fb_src_addr, fb_dst_addr;
    logic [7:0]        pix_format, mode_sel;

    int n_chk = 0, n_bad = 0, done_cnt = 0;
    logic [1:0] last_bresp, last_rresp;

    always #5 clk = ~clk;

    // kernel model: acknowledges a start when idle, completes LAT cycles later
    logic busy = 1'b0;
    int   cnt  = 0;
    logic kd   = 1'b0;
    assign k_ready = k_start && !busy;
    assign k_idle  = !busy;
    assign k_done  = kd;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cnt <= 0; kd <= 1'b0;
        end else begin
            kd <= 1'b0;
            if (!busy && k_start) begin
                busy <= 1'b1; cnt <= LAT;
            end else if (busy) begin
                if (cnt == 1) begin
                    busy <= 1'b0; kd <= 1'b1; done_cnt <= done_cnt + 1;
                end
                cnt <= cnt - 1;
            end
        end
    end

    accel_ctl_slave #(.ADDR_W(ADDR_W)) i_accel_ctl_slave (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = be; s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        while (!s_bvalid) @(negedge clk);
        last_bresp = s_bresp;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata; last_rresp = s_rresp;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 k_start", 32'(k_start), 0);
        bus_rd(6'h00, v); chk("R1 ctrl", v, 32'h04);
        bus_rd(6'h0C, v); chk("R1 status", v, 0);
        bus_rd(6'h10, v); chk("R1 fb src", v, 0);
        bus_rd(6'h28, v); chk("R1 mode", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_wr(6'h10, 32'hFFFF_FFFF, 4'hF);
        bus_wr(6'h10, 32'h1234_5678, 4'b0101);
        bus_rd(6'h10, v); chk("R2 strobe merge", v, 32'hFF34_FF78);
        chk("R10 src port", fb_src_addr, 32'hFF34_FF78);
        bus_wr(6'h18, 32'hCAFE_0040, 4'hF);
        bus_rd(6'h18, v); chk("R2 fb dst", v, 32'hCAFE_0040);
        chk("R10 dst port", fb_dst_addr, 32'hCAFE_0040);
        bus_wr(6'h20, 32'hABCD_12A5, 4'hF);
        bus_rd(6'h20, v); chk("R2 fmt low byte", v, 32'hA5);
        bus_wr(6'h28, 32'h0000_003C, 4'hF);
        bus_rd(6'h28, v); chk("R2 mode", v, 32'h3C);
        chk("R10 fmt/mode ports", {16'h0, pix_format, mode_sel}, 32'h0000_A53C);
        bus_wr(6'h28, 32'h0000_0011, 4'h0);
        bus_rd(6'h28, v); chk("R2 zero strobe", v, 32'h3C);
        chk("R11 bresp", 32'(last_bresp), 0);
        chk("R11 rresp", 32'(last_rresp), 0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        bus_wr(6'h14, 32'hFFFF_FFFF, 4'hF);
        bus_rd(6'h14, v); chk("R3 reserved 0x14", v, 0);
        bus_rd(6'h1C, v); chk("R3 reserved 0x1C", v, 0);
        bus_rd(6'h24, v); chk("R3 reserved 0x24", v, 0);
        bus_rd(6'h2C, v); chk("R3 reserved 0x2C", v, 0);
        bus_rd(6'h3C, v); chk("R3 unmapped", v, 0);
        bus_wr(6'h00, 32'h0000_000E, 4'hF);
        bus_rd(6'h00, v); chk("R3 ctrl read-only bits", v, 32'h04);
        chk("R3 no launch", 32'(done_cnt), 0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        int c0;
        c0 = done_cnt;
        bus_wr(6'h00, 32'h1, 4'h0);
        repeat (15) @(posedge clk);
        chk("R4 start needs strobe", 32'(done_cnt), 32'(c0));
        bus_wr(6'h00, 32'h1, 4'h1);
        bus_rd(6'h00, v); chk("R6 busy, start cleared", v, 32'h00);
        repeat (20) @(posedge clk);
        chk("R4 single run", 32'(done_cnt), 32'(c0 + 1));
        chk("R4 start low", 32'(k_start), 0);
        bus_rd(6'h00, v); chk("R5 done sticky", v, 32'h06);
        bus_rd(6'h00, v); chk("R5 done cleared by read", v, 32'h04);
        bus_wr(6'h00, 32'h0, 4'h1);
        repeat (15) @(posedge clk);
        chk("R4 write 0 no effect", 32'(done_cnt), 32'(c0 + 1));
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_rd(6'h0C, v); chk("R7 status set without enables", v, 32'h3);
        chk("R8 irq no enables", 32'(irq), 0);
        bus_wr(6'h08, 32'h1, 4'h1);
        chk("R8 irq gie off", 32'(irq), 0);
        bus_wr(6'h04, 32'h1, 4'h1);
        chk("R8 irq done path", 32'(irq), 1);
        bus_wr(6'h0C, 32'h1, 4'h1);
        chk("R8 irq masked ready", 32'(irq), 0);
        bus_rd(6'h0C, v); chk("R7 toggle clears", v, 32'h2);
        bus_wr(6'h08, 32'h2, 4'h1);
        chk("R8 irq ready path", 32'(irq), 1);
        bus_wr(6'h0C, 32'h0, 4'h1);
        bus_rd(6'h0C, v); chk("R7 write 0 keeps", v, 32'h2);
        bus_wr(6'h0C, 32'h3, 4'h1);
        bus_rd(6'h0C, v); chk("R7 toggle sets", v, 32'h1);
        chk("R8 irq done masked", 32'(irq), 0);
        bus_wr(6'h0C, 32'h1, 4'h1);
        bus_wr(6'h04, 32'h0, 4'h1);
    endtask

    task automatic t_auto();
        logic [31:0] v;
        int c0, c1;
        c0 = done_cnt;
        bus_wr(6'h00, 32'h81, 4'h1);
        repeat (100) @(posedge clk);
        chk("R9 repeated runs", 32'(done_cnt - c0 >= 10), 1);
        bus_rd(6'h00, v); chk("R9 start and auto held", v & 32'h81, 32'h81);
        bus_wr(6'h00, 32'h00, 4'h1);
        repeat (30) @(posedge clk);
        c1 = done_cnt;
        repeat (50) @(posedge clk);
        chk("R9 stops after clear", 32'(done_cnt), 32'(c1));
        chk("R4 start low after stop", 32'(k_start), 0);
        bus_rd(6'h00, v); chk("R6 idle after stop", v & 32'h8D, 32'h04);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_reserved();
        t_start();
        t_irq();
        t_auto();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule